// File: doc/BRIEF.md
# Floppy Controller Clock Selector with Write Guard

This block sits between a floppy disk controller and its drive. It feeds the controller one of two clocks, a fast one (nominally 2 MHz) or a normal one (nominally 1 MHz). A head-step pulse from the controller selects the fast clock, so seeks run quicker. The controller's data request selects the normal clock again. The first data request of a command comes before any write strobe, so data always reaches the medium at normal speed. Because the switch happens at the request and not at the strobe, no clock change can fall inside a write pulse.

A selection request does not reach the output mux at once. It waits for a system-clock edge at which both clock inputs sample low. This keeps runt pulses off the controller's clock pin. The block also gates the controller's write strobe with the drive's active-low write-protect line, so a protected disk never receives a write or erase pulse.

The block runs on a system clock much faster than either selectable clock. It samples both selectable clocks and the control lines with that system clock.

Top module: `fdc_clock_switch`

## Requirements
- R1: After reset the selection is normal speed: `fdc_clk` follows `clk_slow_i`, and `wstb_drv` stays low while `wstb` is low.
- R2: A system-clock edge that samples `step_n` low, `drq` low and `wfde_n` high selects fast speed. From one period of `clk_slow_i` later, `fdc_clk` follows `clk_fast_i`. The selection stays fast after `step_n` returns high.
- R3: A system-clock edge that samples `drq` high selects normal speed. No `fdc_clk` high pulse of fast-clock width begins more than one `clk_slow_i` period after `drq` was seen, so the write strobe that follows is clocked at normal speed.
- R4: When `drq` is high and `step_n` is low at the same edge, the normal speed wins.
- R5: A system-clock edge that samples `wfde_n` low selects normal speed, whatever `step_n` does.
- R6: The clock actually driven changes only at an edge where both clock inputs sample low. Every high or low phase of `fdc_clk` therefore lasts at least one half period of `clk_fast_i`.
- R7: `wstb_drv` equals `wstb` AND `wprt_n`: while `wprt_n` is low (disk protected), no strobe reaches the drive, at either speed.
- R8: While `step_n` is high, `drq` is low and `wfde_n` is high, the selection keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than both selectable clocks |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_fast_i | input | 1 | Fast clock candidate (2 MHz nominal) |
| clk_slow_i | input | 1 | Normal clock candidate (1 MHz nominal) |
| step_n | input | 1 | Head-step pulse from the controller, active low |
| drq | input | 1 | Data request from the controller, active high |
| wfde_n | input | 1 | Write-fault / drive-enable line from the controller, low forces normal speed |
| wstb | input | 1 | Write strobe from the controller, active high |
| wprt_n | input | 1 | Write protect from the drive, active low |
| fdc_clk | output | 1 | Selected clock toward the controller |
| wstb_drv | output | 1 | Gated write strobe toward the drive |

## Verification
Two functions can act in the same cycle. The first is the clock reselection when a data request or step pulse lands. The second is write gating, either a strobe pulse that follows that request or a strobe raised while the disk is protected. The bench places the data request at eight phases of the slow-clock cycle, each time from fast speed, and then issues a strobe. Each run is judged by the absence of any fast-width clock pulse that starts late, and by the strobe reaching the drive. A sweep over every combination of the three control lines, from both start speeds, checks priority and hold. A continuous monitor checks that no clock phase shorter than a fast half period appears.

// File: rtl/fdc_clock_switch.sv
module fdc_clock_switch (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_fast_i,
  input  logic clk_slow_i,
  input  logic step_n,
  input  logic drq,
  input  logic wfde_n,
  input  logic wstb,
  input  logic wprt_n,
  output logic fdc_clk,
  output logic wstb_drv
);

  logic want_fast;
  logic sel_fast;
  logic both_low;

  assign both_low = !clk_fast_i && !clk_slow_i;

  // requested speed: drq and wfde_n force normal, step requests fast
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  want_fast <= 1'b0;
    else if (drq || !wfde_n)     want_fast <= 1'b0;
    else if (!step_n)            want_fast <= 1'b1;
  end

  // applied speed moves only while both candidates are low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_fast <= 1'b0;
    else if (both_low) sel_fast <= want_fast;
  end

  assign fdc_clk  = sel_fast ? clk_fast_i : clk_slow_i;
  assign wstb_drv = wstb & wprt_n;

  assert_step_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_n && !drq && wfde_n) |=> want_fast);

  assert_drq_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drq |=> !want_fast);

  assert_drq_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && !step_n) |=> !want_fast);

  assert_wfde_normal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wfde_n |=> !want_fast);

  assert_clean_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_fast) |-> $past(!clk_fast_i && !clk_slow_i));

  assert_protect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wprt_n |-> !wstb_drv);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_n && !drq && wfde_n) |=> $stable(want_fast));

endmodule

// File: tb/test_fdc_clock_switch.sv
module test_fdc_clock_switch;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cf = 1'b0, cs = 1'b0;
  logic step_n = 1'b1, drq = 1'b0, wfde_n = 1'b1, wstb = 1'b0, wprt_n = 1'b1;
  logic fdc_clk, wstb_drv;

  int checks = 0, failures = 0;
  int ph = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fdc_clock_switch i_fdc_clock_switch (
    .clk(clk), .rst_n(rst_n), .clk_fast_i(cf), .clk_slow_i(cs),
    .step_n(step_n), .drq(drq), .wfde_n(wfde_n), .wstb(wstb), .wprt_n(wprt_n),
    .fdc_clk(fdc_clk), .wstb_drv(wstb_drv));

  // fast: 100-cycle period, slow: 200-cycle period, both low for ph 0..49
  always @(negedge clk) begin
    ph <= (ph == 199) ? 0 : ph + 1;
    cf <= ((ph + 1) % 200 % 100) >= 50;
    cs <= ((ph + 1) % 200) >= 100;
  end

  // pulse monitor
  logic prev = 1'b0;
  bit   mon_valid = 1'b0;
  int   width = 0, t_rise = 0, drq_cyc = 0;
  bit   window = 1'b0;
  int   glitches = 0, late_fast = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (fdc_clk !== prev) begin
        if (mon_valid && width < 50) glitches <= glitches + 1;
        if (prev && mon_valid && width <= 60 && window && t_rise > drq_cyc + 200)
          late_fast <= late_fast + 1;
        if (fdc_clk) t_rise <= cyc;
        width <= 1;
        mon_valid <= 1'b1;
        prev <= fdc_clk;
      end else if (width < 1000) width <= width + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // follow check over one slow period; fast=1 expects fdc_clk == cf
  task automatic check_follow(input bit fast, input string tag);
    int bad = 0;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk);
      if (fdc_clk !== (fast ? cf : cs)) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic pulse(input bit s_n, input bit d, input bit w_n);
    @(negedge clk);
    step_n = s_n; drq = d; wfde_n = w_n;
    @(negedge clk);
    step_n = 1'b1; drq = 1'b0; wfde_n = 1'b1;
  endtask

  initial begin
    wait_cycles(7);
    // R1: reset state
    check(fdc_clk === cs, "R1 clock during reset", fdc_clk, cs);
    check(wstb_drv === 1'b0, "R1 strobe during reset", wstb_drv, 0);
    @(negedge clk); rst_n = 1'b1;
    wait_cycles(10);
    check_follow(1'b0, "R1 normal after reset");

    // R7: strobe gating truth table at normal speed
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); wstb = m[0]; wprt_n = m[1];
      #1 check(wstb_drv === (m[0] & m[1]), "R7 gate normal", wstb_drv, m[0] & m[1]);
    end
    @(negedge clk); wstb = 1'b0; wprt_n = 1'b1;

    // sweep: start speed x control combination (R2 R4 R5 R8)
    for (int st = 0; st < 2; st++) begin
      for (int c = 0; c < 8; c++) begin
        bit s_n, d, w_n, exp;
        s_n = c[0]; d = c[1]; w_n = c[2];
        if (st == 1) pulse(1'b0, 1'b0, 1'b1); else pulse(1'b1, 1'b1, 1'b1);
        wait_cycles(250);
        pulse(s_n, d, w_n);
        if (d || !w_n) exp = 1'b0;
        else if (!s_n) exp = 1'b1;
        else exp = st[0];
        wait_cycles(250);
        if (d && !s_n)        check_follow(exp, "R4 drq over step");
        else if (!w_n)        check_follow(exp, "R5 wfde forces normal");
        else if (d)           check_follow(exp, "R3 drq normal");
        else if (!s_n)        check_follow(exp, "R2 step fast");
        else                  check_follow(exp, "R8 hold");
      end
    end

    // R7: gating while fast
    pulse(1'b0, 1'b0, 1'b1);
    wait_cycles(250);
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); wstb = m[0]; wprt_n = m[1];
      #1 check(wstb_drv === (m[0] & m[1]), "R7 gate fast", wstb_drv, m[0] & m[1]);
    end
    @(negedge clk); wstb = 1'b0; wprt_n = 1'b1;

    // R3: drq at eight phases from fast, then a write strobe
    for (int p = 0; p < 8; p++) begin
      pulse(1'b0, 1'b0, 1'b1);
      wait_cycles(250);
      while (ph != p * 25) @(negedge clk);
      drq = 1'b1; drq_cyc = cyc; window = 1'b1;
      @(negedge clk); drq = 1'b0;
      wait_cycles(400);
      wstb = 1'b1; window = 1'b0;
      #1 check(wstb_drv === 1'b1, "R7 strobe passes unprotected", wstb_drv, 1);
      check(late_fast == 0, "R3 no fast pulse before strobe", late_fast, 0);
      @(negedge clk); wprt_n = 1'b0;
      #1 check(wstb_drv === 1'b0, "R7 strobe blocked protected", wstb_drv, 0);
      @(negedge clk); wstb = 1'b0; wprt_n = 1'b1;
      check_follow(1'b0, "R3 normal after drq");
    end

    check(glitches == 0, "R6 no short clock phase", glitches, 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule